// File: doc/BRIEF.md
# Host controller interrupt aggregator

This block collects the interrupt causes of a USB host controller into one status word, masks them with a software-owned enable word, and drives one level-sensitive interrupt request line. Event sources elsewhere in the controller raise one-cycle pulses. Each pulse sets a sticky status bit. Software reads the status word and acknowledges causes by writing ones back to it.

Software changes the enable word through two separate addresses. A write to the set address turns bits on, and a write to the clear address turns bits off. Either address reads back the current enable word. Bit 31 of the enable word is a master gate. The request line is high only when the master gate is on and at least one enabled cause is pending.

Register access is a simple 32-bit, word-aligned write strobe with a combinational read port. The request line comes from a two-state machine:
- States: `IRQ_QUIET` (line low) and `IRQ_RAISED` (line high).
- Transition *raise* (`IRQ_QUIET` to `IRQ_RAISED`): taken when the gated condition is true.
- Transition *drop* (`IRQ_RAISED` to `IRQ_QUIET`): taken when the gated condition is false.

Top module: `intagg_top`

## Requirements
- R1: After reset the status word is 0x0000_0000, the enable word is 0x8000_0000 (master gate only) and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k. This applies to k = 0 (schedule overrun), 1 (done list written), 2 (frame start), 3 (resume seen), 4 (fatal error), 5 (frame counter wrap), 6 (hub change) and 30 (ownership change). A set bit stays set until cleared. Pulses on other lines have no effect, and those status bits read 0.
- R3: A write to the status address (byte offset 0x00) clears every status bit written as 1. Bits written as 0 are unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the enable-set address (0x04) ORs the written value into the enable word. Only bits 0–6, 30 and 31 are stored; the other bits always read 0.
- R6: A write to the enable-clear address (0x08) clears every enable bit written as 1 and leaves the rest unchanged.
- R7: Reading 0x00 returns the status word. Reading 0x04 or 0x08 returns the enable word. Any other aligned address reads 0, and writes to it change nothing.
- R8: `irq_o` is high exactly when enable bit 31 is set and (status AND enable) is nonzero. It is registered, so it follows a register change one clock later.
- R9: An access whose two low address bits are not 00 is ignored for writes and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | One-cycle event pulses, one line per status bit |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A corrupted status or enable bit is visible on the next combinational read of its address. It also shows on `irq_o` one clock later, because the line is a registered copy of the gated condition. A stale or missed state transition therefore shows as `irq_o` disagreeing with the status and enable words read one cycle earlier. A clearing write that wins over a simultaneous event would read back as a missing status bit immediately after that edge.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    localparam int unsigned DATA_W = 32;

    // status bits that have a cause behind them
    localparam logic [DATA_W-1:0] EVT_IMPL  = 32'h4000_007F;
    localparam int unsigned       GATE_BIT  = 31;
    localparam logic [DATA_W-1:0] MASK_IMPL = EVT_IMPL | (32'h1 << GATE_BIT);

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/intagg_regdec.sv
module intagg_regdec #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned OFS_STATUS = 0,
    parameter int unsigned OFS_EN_SET = 4,
    parameter int unsigned OFS_EN_CLR = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_status_o,
    output logic              hit_set_o,
    output logic              hit_clr_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_EN_CLR);

    logic aligned;

    always_comb begin
        aligned      = (addr_i[1:0] == 2'b00);
        hit_status_o = aligned && (addr_i == A_STATUS);
        hit_set_o    = aligned && (addr_i == A_SET);
        hit_clr_o    = aligned && (addr_i == A_CLR);
    end
endmodule

// File: rtl/intagg_status.sv
module intagg_status
    import intagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              ack_we_i,
    input  logic [DATA_W-1:0] ack_data_i,
    output logic [DATA_W-1:0] status_o
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] new_bits;

    always_comb begin
        clr_bits = ack_we_i ? ack_data_i : '0;
        new_bits = evt_i & EVT_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | new_bits;
    end

    assign status_o = status_q;

    // R4: an event pulse wins over a same-cycle acknowledge
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & EVT_IMPL)) |=> ((status_q & $past(evt_i & EVT_IMPL)) == $past(evt_i & EVT_IMPL)));

    // R3: acknowledged bits without a new event are gone next cycle
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> ((status_q & $past(ack_data_i & ~evt_i)) == '0));
endmodule

// File: rtl/intagg_mask.sv
module intagg_mask
    import intagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_we_i) mask_d = mask_d | (wdata_i & MASK_IMPL);
        if (clr_we_i) mask_d = mask_d & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= (DATA_W'(1) << GATE_BIT);
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R5: set-port write turns the stored bits on
    a_r5_set_port: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((mask_q & $past(wdata_i & MASK_IMPL)) == $past(wdata_i & MASK_IMPL)));

    // R6: clear-port write turns the written bits off
    a_r6_clr_port: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/intagg_irq_fsm.sv
module intagg_irq_fsm
    import intagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (want_i)  state_d = IRQ_RAISED;   // raise
            IRQ_RAISED: if (!want_i) state_d = IRQ_QUIET;    // drop
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R8: line follows the gated condition one cycle later
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        want_i |=> irq_o);
    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !want_i |=> !irq_o);
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned OFS_STATUS = 0,
    parameter int unsigned OFS_EN_SET = 4,
    parameter int unsigned OFS_EN_CLR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       evt_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    logic              hit_status;
    logic              hit_set;
    logic              hit_clr;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] mask;
    logic              want;

    intagg_regdec #(
        .ADDR_W    (ADDR_W),
        .OFS_STATUS(OFS_STATUS),
        .OFS_EN_SET(OFS_EN_SET),
        .OFS_EN_CLR(OFS_EN_CLR)
    ) u_dec (
        .addr_i      (bus_addr_i),
        .hit_status_o(hit_status),
        .hit_set_o   (hit_set),
        .hit_clr_o   (hit_clr)
    );

    intagg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .ack_we_i  (bus_we_i && hit_status),
        .ack_data_i(bus_wdata_i),
        .status_o  (status)
    );

    intagg_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we_i(bus_we_i && hit_set),
        .clr_we_i(bus_we_i && hit_clr),
        .wdata_i (bus_wdata_i),
        .mask_o  (mask)
    );

    always_comb begin
        want = mask[GATE_BIT] && (|(status & mask));
    end

    intagg_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .want_i(want),
        .irq_o (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (hit_status)           bus_rdata_o = status;
        else if (hit_set || hit_clr) bus_rdata_o = mask;
    end

    // R9: misaligned addresses read as zero
    a_r9_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_o == '0));

    // R2: status never holds a bit without a cause behind it
    a_r2_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~EVT_IMPL) == '0));
endmodule

// File: tb/intagg_top_tb_top.sv
module intagg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intagg_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .bus_addr_i (addr),
        .bus_we_i   (we),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic        w;
        logic [31:0] d;
        logic [31:0] e;
        logic [31:0] st;
        logic [31:0] mk;
        logic        iq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 32'h0,         32'h0000_0004, 32'h0000_0004, 32'h8000_0000, 1'b0, 4'd2}, // R2 frame start
        '{8'h04, 1'b1, 32'h0000_0004, 32'h0,         32'h0000_0004, 32'h8000_0004, 1'b1, 4'd5}, // R5 R8
        '{8'h00, 1'b0, 32'h0,         32'h0000_0081, 32'h0000_0005, 32'h8000_0004, 1'b1, 4'd2}, // R2 bit 7 ignored
        '{8'h00, 1'b1, 32'h0000_0004, 32'h0,         32'h0000_0001, 32'h8000_0004, 1'b0, 4'd3}, // R3 R8
        '{8'h04, 1'b1, 32'hFFFF_FFFF, 32'h0,         32'h0000_0001, 32'hC000_007F, 1'b1, 4'd5}, // R5 stored bits only
        '{8'h08, 1'b1, 32'h8000_0000, 32'h0,         32'h0000_0001, 32'h4000_007F, 1'b0, 4'd6}, // R6 R8 gate off
        '{8'h04, 1'b1, 32'h8000_0000, 32'h0,         32'h0000_0001, 32'hC000_007F, 1'b1, 4'd5}, // R5 gate on
        '{8'h00, 1'b1, 32'h0,         32'h0,         32'h0000_0001, 32'hC000_007F, 1'b1, 4'd3}, // R3 zeros ignored
        '{8'h00, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'hC000_007F, 1'b1, 4'd4}, // R4 event wins
        '{8'h00, 1'b1, 32'h0000_0001, 32'h4000_0000, 32'h4000_0000, 32'hC000_007F, 1'b1, 4'd3}, // R3 R2 bit 30
        '{8'h05, 1'b1, 32'hFFFF_FFFF, 32'h0,         32'h4000_0000, 32'hC000_007F, 1'b1, 4'd9}, // R9 misaligned
        '{8'h08, 1'b1, 32'h4000_007F, 32'h0,         32'h4000_0000, 32'h8000_0000, 1'b0, 4'd6}, // R6
        '{8'h0C, 1'b1, 32'hFFFF_FFFF, 32'h0,         32'h4000_0000, 32'h8000_0000, 1'b0, 4'd7}  // R7 unmapped
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // drive one op at a negedge, let irq settle one extra edge, sample at negedge
    task automatic apply(input logic [7:0] a, input logic w, input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        addr = a; we = w; wdata = d; evt = e;
        @(negedge clk);
        we = 1'b0; evt = '0; wdata = '0;
        @(negedge clk);
    endtask

    task automatic check_regs(input string tag, input logic [31:0] st, input logic [31:0] mk, input logic iq);
        logic [31:0] v;
        rd(8'h00, v); chk({tag, " status"}, v, st);
        rd(8'h04, v); chk({tag, " mask@set"}, v, mk);
        rd(8'h08, v); chk({tag, " mask@clr R7"}, v, mk);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, iq});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 reset", 32'h0, 32'h8000_0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].a, VEC[i].w, VEC[i].d, VEC[i].e);
            check_regs($sformatf("vec%0d R%0d", i, VEC[i].req), VEC[i].st, VEC[i].mk, VEC[i].iq);
        end

        // R9: misaligned read of a live register returns 0
        rd(8'h01, v); chk("R9 misaligned read", v, 32'h0);
        // R7: unmapped aligned read returns 0
        rd(8'h10, v); chk("R7 unmapped read", v, 32'h0);

        // R8: one-cycle latency of the line
        @(negedge clk);
        addr = 8'h04; we = 1'b1; wdata = 32'h4000_0000;
        @(posedge clk); #1;
        we = 1'b0; wdata = '0;
        chk("R8 line not yet up", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        chk("R8 line up after one clock", {31'b0, irq}, 32'h1);

        // R1: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 re-reset", 32'h0, 32'h8000_0000, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule